// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a small serial EEPROM over four wires: a select line, a serial clock, a line toward the memory, and a line back from it. The host presents one command together with an address and, for a program operation, a 16-bit word. The block turns this into a single bit stream sent most significant bit first. The stream holds a start bit, a two-bit operation code, the address and, where the operation needs it, a 16-bit data field. When the command is a fetch, the block assembles the returned word from the samples it takes while the serial clock is high.

Two details of the device are learned at run time rather than set at build time. The first is the address width, which is either the narrow or the wide value. The block finds it with a probe fetch that always sends the wide address. A narrow device starts driving its zero marker bit earlier than a wide one, and the block checks for that bit. The second is the end of a program or clear cycle. After the frame the block drops the select line briefly, raises it again, and samples the return line once per half period until the line goes high or a sample budget runs out.

Top module: `uwire_rom_master`

## Requirements
- R1: After reset, ee_cs, ee_sk, ee_di, busy, poll_timeout and addr_wide are 0 and rd_data is 0. addr_wide = 0 means the narrow address width (AW_NARROW = 6).
- R2: A command is accepted when cmd_valid is high while busy is low. busy rises on the clock edge that accepts the command and falls on the edge that drives ee_cs low for the last time in that command. cmd_valid has no effect while busy is high.
- R3: Every frame starts with a 1 start bit, then two operation bits, then the address (6 bits if addr_wide is 0, 8 bits if it is 1), all sent most significant bit first. The three leading bits are 110 for a fetch, 101 for a program and 111 for a clear. ee_di changes only while ee_sk is low, and ee_sk is high only while ee_cs is high.
- R4: A fetch (cmd_op = 0) sends 16 extra clock cycles with ee_di at 0 after the address. ee_do is sampled at the end of each high phase, and rd_data holds the last 16 samples, first sample in bit 15, once busy falls.
- R5: A probe (cmd_op = 5) sends 110, eight address ones and 16 zero bits, 27 bits in all. It sets addr_wide to the ee_do sample taken in the high phase of the ninth bit (start bit = first).
- R6: Write-enable (cmd_op = 3) sends 3 + width bits equal to 0x4F shifted left by (width − 4). Write-disable (cmd_op = 4) sends the same length with value 0x40 shifted left by (width − 4).
- R7: A program (cmd_op = 1) sends the header, the address and cmd_wdata (16 bits). It then holds ee_cs low for one half period, raises ee_cs again, and samples ee_do once per half period until a 1 is seen. ee_cs then drops and busy falls.
- R8: A clear (cmd_op = 2) sends only the header and the address, then runs the same low gap and ready poll as a program.
- R9: If POLL_MAX poll samples are all 0, the block drops ee_cs, ends the command and sets poll_timeout. poll_timeout is cleared when the next command is accepted.
- R10: Each high phase and each low phase of ee_sk inside a frame lasts exactly HALF_DIV clock cycles. The default of 500 gives 10 µs at a 50 MHz clock.
- R11: Operation codes are 0 fetch, 1 program, 2 clear, 3 write-enable, 4 write-disable and 5 probe. Codes 6 and 7 are not accepted: busy and ee_cs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 3 | Operation code (see R11) |
| cmd_addr | input | AW_WIDE (8) | Word address; upper bits are ignored at narrow width |
| cmd_wdata | input | DW (16) | Word to program |
| busy | output | 1 | A command is in progress |
| rd_data | output | DW (16) | Word returned by the last fetch |
| addr_wide | output | 1 | Discovered width: 1 = 8 bits, 0 = 6 bits |
| poll_timeout | output | 1 | The last ready poll ran out of samples |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the device |
| ee_do | input | 1 | Serial data from the device (idles high) |

## Verification
The bench attaches a behavioural memory model whose address width can be switched. It runs the probe against both widths: a design that samples the wrong bit position, or samples on the wrong phase, reports the wrong width, and every later frame then has the wrong length. Program and clear are read back through a later fetch. A design that never opens the select gap leaves the model's cycle uncommitted, and a design that polls with the select line low sees the idle-high line and never times out. The bench also measures the clock phase widths, re-issues a command while busy, and sends the two unused codes, to catch a block that starts a second frame or wakes up on an illegal operation.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_ERASE = 3'd2,
      OP_WREN  = 3'd3,
      OP_WRDIS = 3'd4,
      OP_PROBE = 3'd5
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LO,
      ST_HI,
      ST_GAP,
      ST_POLL
   } st_e;

endpackage

// File: rtl/uwire_half_tick.sv
module uwire_half_tick #(
   parameter int HALF_DIV = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart || tick)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   initial begin
      AST_DIV_RANGE: assert (HALF_DIV >= 2) else $error("HALF_DIV must be at least 2"); // R10
   end
endmodule

// File: rtl/uwire_frame_gen.sv
module uwire_frame_gen
   import uwire_pkg::*;
#(
   parameter int AW_NARROW = 6,
   parameter int AW_WIDE   = 8,
   parameter int DW        = 16,
   parameter int FRAME_W   = 3 + AW_WIDE + DW,
   parameter int LEN_W     = $clog2(FRAME_W + 1)
) (
   input  logic [2:0]         op,
   input  logic [AW_WIDE-1:0] addr,
   input  logic [DW-1:0]      wdata,
   input  logic               wide,
   output logic [FRAME_W-1:0] frame,
   output logic [LEN_W-1:0]   len,
   output logic               op_ok
);
   always_comb begin
      int                 aw;
      logic [2:0]         hdr;
      logic [AW_WIDE-1:0] a;
      logic [DW-1:0]      d;
      logic               with_data;
      aw        = wide ? AW_WIDE : AW_NARROW;
      hdr       = 3'b100;
      a         = '0;
      d         = '0;
      with_data = 1'b0;
      op_ok     = 1'b1;
      case (op_e'(op))
         OP_READ:  begin hdr = 3'b110; a = addr; with_data = 1'b1; end
         OP_WRITE: begin hdr = 3'b101; a = addr; d = wdata; with_data = 1'b1; end
         OP_ERASE: begin hdr = 3'b111; a = addr; end
         OP_WREN:  a = AW_WIDE'(4'hF) << (aw - 4);
         OP_WRDIS: a = '0;
         OP_PROBE: begin hdr = 3'b110; aw = AW_WIDE; a = '1; with_data = 1'b1; end
         default:  op_ok = 1'b0;
      endcase
      a     = a & AW_WIDE'((1 << aw) - 1);
      frame = (FRAME_W'(hdr) << (FRAME_W - 3))
            | (FRAME_W'(a)   << (FRAME_W - 3 - aw))
            | (FRAME_W'(d)   << (FRAME_W - 3 - aw - DW));
      len   = with_data ? LEN_W'(3 + aw + DW) : LEN_W'(3 + aw);
   end

   initial begin
      AST_AW_ORDER: assert (AW_WIDE > AW_NARROW && AW_NARROW >= 4) else $error("address widths out of range"); // R5
   end
endmodule

// File: rtl/uwire_rom_master.sv
module uwire_rom_master
   import uwire_pkg::*;
#(
   parameter int HALF_DIV  = 500,
   parameter int POLL_MAX  = 10000,
   parameter int AW_NARROW = 6,
   parameter int AW_WIDE   = 8,
   parameter int DW        = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [AW_WIDE-1:0] cmd_addr,
   input  logic [DW-1:0]      cmd_wdata,
   output logic               busy,
   output logic [DW-1:0]      rd_data,
   output logic               addr_wide,
   output logic               poll_timeout,
   output logic               ee_cs,
   output logic               ee_sk,
   output logic               ee_di,
   input  logic               ee_do
);
   localparam int FRAME_W   = 3 + AW_WIDE + DW;
   localparam int LEN_W     = $clog2(FRAME_W + 1);
   localparam int POLL_W    = $clog2(POLL_MAX + 1);
   localparam int PROBE_IDX = 3 + AW_NARROW - 1;

   st_e                state_q;
   op_e                op_q;
   logic [FRAME_W-1:0] frame_q, frame_d;
   logic [LEN_W-1:0]   left_q, len_d, idx_q;
   logic [DW-1:0]      cap_q;
   logic [POLL_W-1:0]  poll_q;
   logic               probe_q, op_ok, accept, half_tick;

   assign busy   = (state_q != ST_IDLE);
   assign accept = (state_q == ST_IDLE) && cmd_valid && op_ok;

   uwire_frame_gen #(
      .AW_NARROW(AW_NARROW), .AW_WIDE(AW_WIDE), .DW(DW),
      .FRAME_W(FRAME_W), .LEN_W(LEN_W)
   ) frame_i (
      .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata), .wide(addr_wide),
      .frame(frame_d), .len(len_d), .op_ok(op_ok)
   );

   uwire_half_tick #(.HALF_DIV(HALF_DIV)) tick_i (
      .clk(clk), .rst_n(rst_n), .restart(accept), .tick(half_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         op_q         <= OP_READ;
         frame_q      <= '0;
         left_q       <= '0;
         idx_q        <= '0;
         cap_q        <= '0;
         poll_q       <= '0;
         probe_q      <= 1'b0;
         rd_data      <= '0;
         addr_wide    <= 1'b0;
         poll_timeout <= 1'b0;
         ee_cs        <= 1'b0;
         ee_sk        <= 1'b0;
         ee_di        <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               op_q         <= op_e'(cmd_op);
               frame_q      <= frame_d << 1;
               ee_di        <= frame_d[FRAME_W-1];
               left_q       <= len_d;
               idx_q        <= '0;
               probe_q      <= 1'b0;
               poll_timeout <= 1'b0;
               ee_cs        <= 1'b1;
               ee_sk        <= 1'b0;
               state_q      <= ST_LO;
            end
            ST_LO: if (half_tick) begin
               ee_sk   <= 1'b1;
               state_q <= ST_HI;
            end
            ST_HI: if (half_tick) begin
               cap_q <= {cap_q[DW-2:0], ee_do};
               if (idx_q == LEN_W'(PROBE_IDX)) probe_q <= ee_do;
               idx_q  <= idx_q + 1'b1;
               left_q <= left_q - 1'b1;
               ee_sk  <= 1'b0;
               if (left_q == LEN_W'(1)) begin
                  ee_di <= 1'b0;
                  ee_cs <= 1'b0;
                  case (op_q)
                     OP_READ:  begin rd_data <= {cap_q[DW-2:0], ee_do}; state_q <= ST_IDLE; end
                     OP_PROBE: begin addr_wide <= probe_q; state_q <= ST_IDLE; end
                     OP_WRITE, OP_ERASE: state_q <= ST_GAP;
                     default:  state_q <= ST_IDLE;
                  endcase
               end else begin
                  ee_di   <= frame_q[FRAME_W-1];
                  frame_q <= frame_q << 1;
                  state_q <= ST_LO;
               end
            end
            ST_GAP: if (half_tick) begin
               ee_cs   <= 1'b1;
               poll_q  <= '0;
               state_q <= ST_POLL;
            end
            ST_POLL: if (half_tick) begin
               if (ee_do) begin
                  ee_cs   <= 1'b0;
                  state_q <= ST_IDLE;
               end else if (poll_q == POLL_W'(POLL_MAX - 1)) begin
                  poll_timeout <= 1'b1;
                  ee_cs        <= 1'b0;
                  state_q      <= ST_IDLE;
               end else begin
                  poll_q <= poll_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   initial begin
      AST_POLL_PARAM: assert (POLL_MAX >= 1) else $error("POLL_MAX must be positive"); // R9
   end

   AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ee_cs && !ee_sk)); // R2
   AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs); // R3
   AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> $stable(ee_di)); // R3
   AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ee_sk) || $fell(ee_sk)) |-> $past(half_tick)); // R10
   AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(poll_timeout) |-> (!busy && !ee_cs)); // R9
   AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op > 3'd5 && !busy) |=> !busy); // R11
endmodule

// File: tb/uwire_rom_master_tb.sv
module uwire_rom_master_tb_top;
   localparam int HALF = 4;
   localparam int PMAX = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [7:0]  cmd_addr = 8'd0;
   logic [15:0] cmd_wdata = 16'd0;
   logic        busy, addr_wide, poll_timeout, ee_cs, ee_sk, ee_di;
   logic [15:0] rd_data;
   logic        ee_do = 1'b1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   uwire_rom_master #(.HALF_DIV(HALF), .POLL_MAX(PMAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .rd_data(rd_data),
      .addr_wide(addr_wide), .poll_timeout(poll_timeout), .ee_cs(ee_cs),
      .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   // behavioural memory model, switchable address width
   int          rsp_aw = 6;
   int          rsp_delay = 30;
   logic [15:0] mem [256];
   logic        cs_d, sk_d, started, rmode, rval, wen, pend;
   int          n, dcnt, busy_cnt, rsp_cnt, last_cnt;
   logic [1:0]  r_op;
   logic [7:0]  r_addr;
   logic [15:0] r_dat, rword;
   logic [63:0] rsp_log, last_log;

   function automatic logic [15:0] exp_word(input int a);
      return 16'hA000 ^ 16'(a * 16'h0123);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = exp_word(i);
         cs_d = 0; sk_d = 0; started = 0; rmode = 0; rval = 1; wen = 0; pend = 0;
         n = 0; dcnt = 0; busy_cnt = 0; rsp_cnt = 0; last_cnt = 0;
         r_op = 0; r_addr = 0; r_dat = 0; rword = 0; rsp_log = 0; last_log = 0;
         ee_do <= 1'b1;
      end else begin
         if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
         if (ee_cs && !cs_d) begin
            rsp_cnt = 0; rsp_log = 0; started = 0; n = 0; rmode = 0; r_addr = 0; r_op = 0;
         end
         if (!ee_cs && cs_d) begin
            if (rsp_cnt > 0) begin last_cnt = rsp_cnt; last_log = rsp_log; end
            if (pend) busy_cnt = rsp_delay;
            pend = 0; rmode = 0; started = 0;
         end
         if (ee_cs && ee_sk && !sk_d) begin
            rsp_cnt = rsp_cnt + 1;
            rsp_log = {rsp_log[62:0], ee_di};
            if (!started) begin
               if (ee_di) begin started = 1; n = 1; end
            end else begin
               n = n + 1;
               if (n <= 3) r_op = {r_op[0], ee_di};
               else if (n <= 3 + rsp_aw) r_addr = {r_addr[6:0], ee_di};
               else if (r_op == 2'b01 && n <= 3 + rsp_aw + 16) r_dat = {r_dat[14:0], ee_di};
               if (n == 3 + rsp_aw) begin
                  case (r_op)
                     2'b10: begin rmode = 1; rval = 0; rword = mem[r_addr]; dcnt = 0; end
                     2'b11: if (wen) begin mem[r_addr] = 16'hFFFF; pend = 1; end
                     2'b00: begin
                        if (((r_addr >> (rsp_aw - 2)) & 8'd3) == 8'd3) wen = 1;
                        else if (((r_addr >> (rsp_aw - 2)) & 8'd3) == 8'd0) wen = 0;
                     end
                     default: ;
                  endcase
               end else if (n > 3 + rsp_aw) begin
                  if (rmode && dcnt < 16) begin rval = rword[15 - dcnt]; dcnt = dcnt + 1; end
                  else if (rmode) rval = 1;
                  if (r_op == 2'b01 && n == 3 + rsp_aw + 16 && wen) begin
                     mem[r_addr] = r_dat; pend = 1;
                  end
               end
            end
         end
         cs_d = ee_cs;
         sk_d = ee_sk;
         ee_do <= !ee_cs ? 1'b1 : (rmode ? rval : (busy_cnt == 0));
      end
   end

   // serial clock phase widths inside a frame
   int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
   always @(posedge clk) begin
      if (ee_sk) hi_run = hi_run + 1;
      else begin if (hi_run > 0) last_hi = hi_run; hi_run = 0; end
      if (ee_cs && !ee_sk) lo_run = lo_run + 1;
      else begin if (lo_run > 0) last_lo = lo_run; lo_run = 0; end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int k = 0;
      while (busy && k < 5000) begin @(negedge clk); k++; end
      if (k >= 5000) chk("R2 busy never fell", 64'(busy), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic run(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
      issue(op, a, d);
      wait_idle();
   endtask

   task automatic t_reset();
      chk("R1 cs", 64'(ee_cs), 0); chk("R1 sk", 64'(ee_sk), 0);
      chk("R1 di", 64'(ee_di), 0); chk("R1 busy", 64'(busy), 0);
      chk("R1 timeout", 64'(poll_timeout), 0); chk("R1 width", 64'(addr_wide), 0);
      chk("R1 rd_data", 64'(rd_data), 0);
   endtask

   task automatic t_probe(input int aw, input logic exp_wide);
      rsp_aw = aw;
      run(3'd5, 8'h00, 16'h0);
      chk("R5 probe width", 64'(addr_wide), 64'(exp_wide));
      chk("R5 probe length", 64'(last_cnt), 27);
      chk("R5 probe bits", last_log[26:0], {3'b110, 8'hFF, 16'h0});
   endtask

   task automatic t_read_narrow();
      run(3'd0, 8'h15, 16'h0);
      chk("R3 fetch length", 64'(last_cnt), 25);
      chk("R3 fetch bits", last_log[24:0], {3'b110, 6'h15, 16'h0});
      chk("R4 fetch word", 64'(rd_data), 64'(exp_word(8'h15)));
      chk("R10 high phase", 64'(last_hi), HALF);
      chk("R10 low phase", 64'(last_lo), HALF);
   endtask

   task automatic t_write_erase();
      run(3'd3, 8'h00, 16'h0);
      chk("R6 enable length", 64'(last_cnt), 9);
      chk("R6 enable bits", last_log[8:0], 9'h13C);
      run(3'd1, 8'h21, 16'h5AC3);
      chk("R7 program bits", last_log[24:0], {3'b101, 6'h21, 16'h5AC3});
      chk("R7 no timeout", 64'(poll_timeout), 0);
      run(3'd0, 8'h21, 16'h0);
      chk("R7 program readback", 64'(rd_data), 64'h5AC3);
      run(3'd2, 8'h21, 16'h0);
      chk("R8 clear bits", {last_cnt[7:0], 55'(last_log[8:0])}, {8'd9, 55'({3'b111, 6'h21})});
      chk("R8 no timeout", 64'(poll_timeout), 0);
      run(3'd0, 8'h21, 16'h0);
      chk("R8 clear readback", 64'(rd_data), 64'hFFFF);
      run(3'd4, 8'h00, 16'h0);
      chk("R6 disable bits", {last_cnt[7:0], 55'(last_log[8:0])}, {8'd9, 55'(9'h100)});
   endtask

   task automatic t_busy_ignore();
      issue(3'd0, 8'h03, 16'h0);
      chk("R2 busy after accept", 64'(busy), 1);
      repeat (3) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 8'h07;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_idle();
      chk("R2 first fetch kept", 64'(rd_data), 64'(exp_word(8'h03)));
      repeat (10) @(negedge clk);
      chk("R2 no second frame", 64'({busy, ee_cs}), 0);
   endtask

   task automatic t_bad_op();
      issue(3'd6, 8'h01, 16'h0);
      chk("R11 code 6 busy", 64'({busy, ee_cs}), 0);
      issue(3'd7, 8'h01, 16'h0);
      repeat (3) @(negedge clk);
      chk("R11 code 7 busy", 64'({busy, ee_cs}), 0);
   endtask

   task automatic t_timeout();
      run(3'd3, 8'h00, 16'h0);
      rsp_delay = 1000;
      run(3'd1, 8'h30, 16'h1234);
      chk("R9 timeout set", 64'(poll_timeout), 1);
      chk("R9 select released", 64'(ee_cs), 0);
      repeat (1100) @(negedge clk);
      rsp_delay = 30;
      issue(3'd0, 8'h30, 16'h0);
      chk("R9 timeout cleared", 64'(poll_timeout), 0);
      wait_idle();
      chk("R9 late program landed", 64'(rd_data), 64'h1234);
   endtask

   task automatic t_wide();
      t_probe(8, 1'b1);
      run(3'd0, 8'hC4, 16'h0);
      chk("R3 wide fetch bits", {last_cnt[7:0], 56'(last_log[26:0])}, {8'd27, 56'({3'b110, 8'hC4, 16'h0})});
      chk("R4 wide fetch word", 64'(rd_data), 64'(exp_word(8'hC4)));
      run(3'd3, 8'h00, 16'h0);
      chk("R6 wide enable bits", {last_cnt[7:0], 56'(last_log[10:0])}, {8'd11, 56'(11'h4F0)});
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_probe(6, 1'b0);
      t_read_narrow();
      t_write_erase();
      t_busy_ignore();
      t_bad_op();
      t_timeout();
      t_wide();
      finished = 1;
      summary();
   end
endmodule